// File: doc/BRIEF.md
# Multiplexed Address/Data Backplane Bus Slave

This block is the board side of a slow, memory-mapped backplane bus. One 16-bit bus carries both the address and the data, one after the other. Three control lines frame each transfer: an address strobe, a write indicator and a data latch.

When the address strobe rises, the slave records the value on the bus. It compares the upper byte of that value with a strapped 8-bit board number. If the two agree and the reserved bit is clear, the board is selected. The selection lasts until the data latch falls.

While selected, a rising data latch with the write indicator high stores the bus value into one of 128 local 16-bit words. When the data latch is high and the write indicator is low, the slave drives the addressed word back onto the bus. At all other times it drives nothing, so the bus stays quiet when idle.

User logic reads any local word through a separate index and data port. All bus inputs arrive asynchronously and are brought into the local clock domain before use.

Top module: `bpl_slave`

## Requirements
- R1: During reset and after it, `busOe` is 0, `busOut` is 0 and every local word reads 0 on `userData`.
- R2: On a rising `addrStrobe`, the bus value becomes the address. Bits [15:8] must equal `boardId`, and bits [6:0] select the word (0..127).
- R3: An address with bit 7 set never selects the board. A following write changes no word, and a following read does not drive the bus.
- R4: While the board is selected, a rising `dataLatch` with `writeInd` high stores the bus value into the addressed word. The new value is visible on `userData` for that index.
- R5: While the board is selected, with `writeInd` low and `dataLatch` high, `busOe` is 1 and `busOut` carries the addressed word. Whenever `busOe` is 0, `busOut` is 0.
- R6: An address whose bits [15:8] differ from `boardId` is ignored. Nothing is written and nothing is driven.
- R7: The selection ends when `dataLatch` falls. A further `dataLatch` pulse without a new address strobe writes nothing and drives nothing.
- R8: Every bus input passes through two flip-flops. `busOe` rises at the second clock edge after `dataLatch` rises and falls at the second edge after it falls. A write is visible on `userData` after the third edge following the `dataLatch` rise.
- R9: Writes to word 0, word 127 and a middle word are independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 16 | Bus value as seen by the board (address or write data) |
| busOut | output | 16 | Read data driven toward the bus; 0 when not driving |
| busOe | output | 1 | Output enable for the bus driver |
| addrStrobe | input | 1 | Address strobe, asynchronous |
| writeInd | input | 1 | High for write transfers, asynchronous |
| dataLatch | input | 1 | Data phase strobe, asynchronous |
| boardId | input | 8 | Strapped board number |
| userAddr | input | 7 | Index of the local word shown to user logic |
| userData | output | 16 | Value of the local word selected by `userAddr` |

## Verification
An input change is seen by the edge detectors after two clock edges. A selection, a stored address or a stored word changes at the third edge. `busOe` follows the data latch level at the second edge.

The bench keeps a history of the inputs it sampled at each edge. Its model acts on the entries that are two and three edges old, and it compares `busOe`, `busOut` and `userData` at every falling clock edge.

Directed checks sample one edge after the data latch rises, where the enable must still be low. They sample again one edge later, where it must be high. Word contents are read only after four or more edges have passed.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;  // take bus value as the address
    logic wrEn;     // store bus value into the addressed word
  } bplStrobe_t;
endpackage

// File: rtl/bpl_sync.sv
module bpl_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/bpl_ctrl.sv
module bpl_ctrl
  import bpl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       asS,
  input  logic       dlS,
  input  logic       wrS,
  input  logic       busMatch,
  output bplStrobe_t stb,
  output logic       busOe
);
  logic asPrev, dlPrev, selected;
  logic asRise, dlRise, dlFall;

  assign asRise = asS & ~asPrev;
  assign dlRise = dlS & ~dlPrev;
  assign dlFall = ~dlS & dlPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asPrev   <= 1'b0;
      dlPrev   <= 1'b0;
      selected <= 1'b0;
    end else begin
      asPrev <= asS;
      dlPrev <= dlS;
      if (dlFall)      selected <= 1'b0;
      else if (asRise) selected <= busMatch;
    end
  end

  always_comb begin
    stb.capAddr = asRise;
    stb.wrEn    = dlRise & selected & wrS;
  end

  assign busOe = selected & dlS & ~wrS;

  AST_SEL_FROM_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selected) |-> $past(asRise)); // R2
  AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    dlFall |=> !selected); // R7
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> selected); // R5
endmodule

// File: rtl/bpl_datapath.sv
module bpl_datapath
  import bpl_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ID_W      = 8,
  parameter int NUM_WORDS = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bplStrobe_t                    stb,
  input  logic [DATA_W-1:0]             busS,
  input  logic [ID_W-1:0]               boardId,
  input  logic                          busOe,
  input  logic [$clog2(NUM_WORDS)-1:0]  userAddr,
  output logic [DATA_W-1:0]             userData,
  output logic [DATA_W-1:0]             busOut,
  output logic                          busMatch
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  // address bits between the word index and the board field must be zero
  localparam logic [DATA_W-1:0] GAP_MASK =
    ({DATA_W{1'b1}} >> ID_W) & ({DATA_W{1'b1}} << IDX_W);

  logic [DATA_W-1:0] regs [NUM_WORDS];
  logic [IDX_W-1:0]  idxReg;

  assign busMatch = (busS[DATA_W-1 -: ID_W] == boardId) &&
                    ((busS & GAP_MASK) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      for (int i = 0; i < NUM_WORDS; i++) regs[i] <= '0;
    end else begin
      if (stb.capAddr) idxReg <= busS[IDX_W-1:0];
      if (stb.wrEn)    regs[idxReg] <= busS;
    end
  end

  assign busOut   = busOe ? regs[idxReg] : '0;
  assign userData = regs[userAddr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> regs[$past(idxReg)] == $past(busS)); // R4
endmodule

// File: rtl/bpl_slave.sv
module bpl_slave
  import bpl_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ID_W      = 8,
  parameter int NUM_WORDS = 128
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DATA_W-1:0]            busIn,
  output logic [DATA_W-1:0]            busOut,
  output logic                         busOe,
  input  logic                         addrStrobe,
  input  logic                         writeInd,
  input  logic                         dataLatch,
  input  logic [ID_W-1:0]              boardId,
  input  logic [$clog2(NUM_WORDS)-1:0] userAddr,
  output logic [DATA_W-1:0]            userData
);
  logic [DATA_W-1:0] busS;
  logic [2:0]        ctlS;
  logic              busMatch;
  bplStrobe_t        stb;

  bpl_sync #(.W(DATA_W)) busSync_i (
    .clk(clk), .rstN(rstN), .din(busIn), .dout(busS));
  bpl_sync #(.W(3)) ctlSync_i (
    .clk(clk), .rstN(rstN), .din({addrStrobe, dataLatch, writeInd}), .dout(ctlS));

  bpl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .asS(ctlS[2]), .dlS(ctlS[1]), .wrS(ctlS[0]),
    .busMatch(busMatch), .stb(stb), .busOe(busOe));

  bpl_datapath #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_WORDS(NUM_WORDS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busS(busS), .boardId(boardId),
    .busOe(busOe), .userAddr(userAddr), .userData(userData),
    .busOut(busOut), .busMatch(busMatch));

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> busOut == '0); // R5
endmodule

// File: tb/bpl_slave_tb.sv
module bpl_slave_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busIn = '0;
  logic [15:0] busOut;
  logic busOe;
  logic addrStrobe = 1'b0, writeInd = 1'b0, dataLatch = 1'b0;
  logic [7:0] boardId = 8'h5A;
  logic [6:0] userAddr = '0;
  logic [15:0] userData;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #(PERIOD/2) clk = ~clk;

  bpl_slave dut_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .addrStrobe(addrStrobe), .writeInd(writeInd), .dataLatch(dataLatch),
    .boardId(boardId), .userAddr(userAddr), .userData(userData));

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {bit as; bit dl; bit wr; int bus;} sample_t;
  sample_t hq[$];
  int modelMem[128];
  bit mSel;
  int mIdx;

  task automatic modelReset();
    sample_t z;
    z = '{0, 0, 0, 0};
    hq.delete();
    for (int i = 0; i < 4; i++) hq.push_front(z);
    for (int i = 0; i < 128; i++) modelMem[i] = 0;
    mSel = 0;
    mIdx = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      sample_t s;
      bit asUp, dlUp, dlDown, matchNow;
      s = '{addrStrobe, dataLatch, writeInd, int'(busIn)};
      hq.push_front(s);
      void'(hq.pop_back());
      asUp   = hq[2].as && !hq[3].as;
      dlUp   = hq[2].dl && !hq[3].dl;
      dlDown = !hq[2].dl && hq[3].dl;
      if (dlUp && mSel && hq[2].wr) modelMem[mIdx] = hq[2].bus;
      matchNow = ((hq[2].bus >> 8) == int'(boardId)) && (((hq[2].bus >> 7) & 1) == 0);
      if (asUp) mIdx = hq[2].bus & 127;
      if (dlDown) mSel = 0;
      else if (asUp) mSel = matchNow;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit eOe;
      int eOut;
      eOe  = mSel && hq[1].dl && !hq[1].wr;
      eOut = eOe ? modelMem[mIdx] : 0;
      chk(busOe == eOe, curReq, "model busOe", busOe, eOe);
      chk(int'(busOut) == eOut, curReq, "model busOut", busOut, eOut);
      chk(int'(userData) == modelMem[userAddr], curReq, "model userData",
          userData, modelMem[userAddr]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic checkWord(input int idx, input int exp, input string tag);
    userAddr = 7'(idx);
    #1;
    chk(int'(userData) == exp, tag, $sformatf("word %0d", idx), userData, exp);
  endtask

  task automatic busCycle(input logic [15:0] a, input bit isWr,
                          input logic [15:0] d, input bit expDrive,
                          input logic [15:0] expVal, input string tag);
    busIn = a;
    step(2);
    addrStrobe = 1'b1;
    step(3);
    addrStrobe = 1'b0;
    writeInd = isWr;
    busIn = isWr ? d : 16'h0;
    step(3);
    dataLatch = 1'b1;
    step(1);
    if (!isWr) chk(busOe == 1'b0, "R8", "oe after one edge", busOe, 0);
    step(1);
    if (!isWr) begin
      chk(busOe == expDrive, tag, "oe after two edges", busOe, expDrive);
      chk(busOut == (expDrive ? expVal : 16'h0), tag, "read data", busOut,
          expDrive ? expVal : 16'h0);
    end
    step(2);
    dataLatch = 1'b0;
    step(1);
    if (!isWr) chk(busOe == expDrive, "R8", "oe one edge after fall", busOe, expDrive);
    step(2);
    chk(busOe == 1'b0, "R8", "oe after latch fall", busOe, 0);
    writeInd = 1'b0;
    step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk(busOe == 1'b0, "R1", "oe in reset", busOe, 0);
    chk(busOut == 16'h0, "R1", "out in reset", busOut, 0);
    rstN = 1'b1;
    step(2);
    checkWord(0, 0, "R1");
    checkWord(127, 0, "R1");

    curReq = "R4";
    busCycle(16'h5A03, 1, 16'h1234, 0, 0, "R4");
    checkWord(3, 16'h1234, "R4");

    curReq = "R5";
    busCycle(16'h5A03, 0, 0, 1, 16'h1234, "R5");

    curReq = "R9";
    busCycle(16'h5A7F, 1, 16'hBEEF, 0, 0, "R9");
    busCycle(16'h5A00, 1, 16'h0001, 0, 0, "R9");
    checkWord(127, 16'hBEEF, "R9");
    checkWord(0, 16'h0001, "R9");
    checkWord(3, 16'h1234, "R9");
    curReq = "R2";
    busCycle(16'h5A7F, 0, 0, 1, 16'hBEEF, "R2");

    curReq = "R3";
    busCycle(16'h5A83, 1, 16'hFFFF, 0, 0, "R3");
    checkWord(3, 16'h1234, "R3");
    busCycle(16'h5A83, 0, 0, 0, 0, "R3");

    curReq = "R6";
    busCycle(16'h3303, 1, 16'h7777, 0, 0, "R6");
    checkWord(3, 16'h1234, "R6");
    busCycle(16'h3300, 0, 0, 0, 0, "R6");

    curReq = "R7";
    busCycle(16'h5A03, 0, 0, 1, 16'h1234, "R7");
    writeInd = 1'b1;
    busIn = 16'hAAAA;
    step(3);
    dataLatch = 1'b1;
    step(3);
    chk(busOe == 1'b0, "R7", "no drive without strobe", busOe, 0);
    dataLatch = 1'b0;
    writeInd = 1'b0;
    step(4);
    checkWord(3, 16'h1234, "R7");
    dataLatch = 1'b1;
    step(3);
    chk(busOe == 1'b0, "R7", "read pulse without strobe", busOe, 0);
    dataLatch = 1'b0;
    step(4);

    curReq = "R8";
    busCycle(16'h5A00, 0, 0, 1, 16'h0001, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule